// File: doc/BRIEF.md
# Minute-Tick Wake-Up Interrupt

This block turns a slow timekeeping pulse into an interrupt source for a processor. A prescaler counts one-second strobes and emits a single-cycle minute tick each time its count wraps. Each tick sets a sticky flag. The flag stays set until software clears it with a clear strobe. Setting the flag does not depend on any enable.

The flag is delivered as a request only when both the source enable and the global interrupt enable are set and the chip is not in its emergency operating mode. The same gated request also drives a wake-up output while the processor reports either its idle state or its power-down state. A sleeping processor can therefore be switched off between minute events and still keep accurate time.

A parameter can remove the prescaler. In that case the tick input is taken directly as the minute tick.

Top module: `minTickIrq`

## Requirements
- R1: While reset is asserted and right after it is released, the flag, the request and the wake-up output are all 0, and the seconds count starts from zero.
- R2: With the prescaler present (the default), the flag rises only on the 60th counted tick-input cycle after reset, and then on every 60th counted cycle after that. It becomes visible one clock after that cycle. The counted cycles 1 to 59 leave the flag unchanged.
- R3: A minute tick sets the flag whatever the values of the source enable, the global enable and the emergency indicator.
- R4: Once set, the flag holds until a cycle with the clear strobe high. It then reads 0 one clock later, unless R5 applies.
- R5: If the clear strobe and a minute tick occur in the same cycle, the flag is 1 one clock later.
- R6: The request is 1 in exactly those cycles where the flag is 1, the source enable is 1, the global enable is 1 and the emergency indicator is 0. The request follows changes of the enables in the same cycle.
- R7: While the emergency indicator is 1, both the request and the wake-up output are 0.
- R8: The wake-up output is 1 exactly when the request is 1 and at least one of the power-down or idle status inputs is 1.
- R9: Each clock cycle with the tick input high counts as one second. Cycles with the tick input low leave the count unchanged, so irregular spacing of the strobes does not shift the minute boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickIn | input | 1 | One-second strobe (or minute strobe when the prescaler is omitted) |
| srcEnable | input | 1 | Enable for this interrupt source |
| globalEnable | input | 1 | Global interrupt enable |
| emergencyMode | input | 1 | High while the chip runs in its emergency mode |
| cpuPowerDown | input | 1 | Processor is in power-down |
| cpuIdle | input | 1 | Processor is idle |
| flagClr | input | 1 | Software clear strobe for the flag |
| irqFlag | output | 1 | Sticky minute-event flag |
| irqReq | output | 1 | Gated interrupt request |
| wakeUp | output | 1 | Wake-up request to a sleeping processor |

## Verification
The flag is the only registered result. It changes one rising edge after the cycle that carries the tick or the clear. The request and the wake-up output are combinational from the flag and the level inputs, so they are due in the same cycle as any input change. The bench holds each input set across one rising edge. It advances its behavioural model for that edge, then compares all three outputs at the following falling edge, before it drives the next input set. Directed checks are placed at those same falling edges: the 59th and 60th counted strobes, the same-cycle clear and tick, and each enable and sleep combination.

// File: rtl/minTickPkg.sv
package minTickPkg;
  // Strobes and qualifiers passed from control to datapath
  typedef struct packed {
    logic setFlag;   // minute tick this cycle
    logic clrFlag;   // software clear this cycle
    logic reqOk;     // all enables met, not in emergency
    logic sleeping;  // processor idle or powered down
  } flagStrb_t;
endpackage

// File: rtl/minTickPrescale.sv
module minTickPrescale #(
  parameter int SEC_PER_MIN   = 60,
  parameter bit USE_PRESCALER = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickIn,
  output logic minuteTick
);
  generate
    if (USE_PRESCALER) begin : g_count
      localparam int CNT_W = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
      localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SEC_PER_MIN - 1);

      logic [CNT_W-1:0] secCnt;
      logic             atLast;

      assign atLast     = (secCnt == LAST_CNT);
      assign minuteTick = tickIn && atLast;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          secCnt <= '0;
        end else if (tickIn) begin
          if (atLast) secCnt <= '0;
          else        secCnt <= secCnt + 1'b1;
        end
      end

      // R2
      count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
        secCnt <= LAST_CNT);
      // R2
      tick_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
        minuteTick |=> (secCnt == '0));
      // R9
      count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        !tickIn |=> $stable(secCnt));
    end else begin : g_direct
      assign minuteTick = tickIn;
    end
  endgenerate
endmodule

// File: rtl/minTickCtrl.sv
module minTickCtrl
  import minTickPkg::*;
#(
  parameter int SEC_PER_MIN   = 60,
  parameter bit USE_PRESCALER = 1'b1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tickIn,
  input  logic      srcEnable,
  input  logic      globalEnable,
  input  logic      emergencyMode,
  input  logic      cpuPowerDown,
  input  logic      cpuIdle,
  input  logic      flagClr,
  output flagStrb_t strb
);
  logic minuteTick;

  minTickPrescale #(
    .SEC_PER_MIN  (SEC_PER_MIN),
    .USE_PRESCALER(USE_PRESCALER)
  ) u_prescale (
    .clk       (clk),
    .rstN      (rstN),
    .tickIn    (tickIn),
    .minuteTick(minuteTick)
  );

  always_comb begin
    strb.setFlag  = minuteTick;
    strb.clrFlag  = flagClr;
    strb.reqOk    = srcEnable && globalEnable && !emergencyMode;
    strb.sleeping = cpuPowerDown || cpuIdle;
  end
endmodule

// File: rtl/minTickData.sv
module minTickData
  import minTickPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  flagStrb_t strb,
  output logic      irqFlag,
  output logic      irqReq,
  output logic      wakeUp
);
  logic flagQ;

  // Set has priority over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             flagQ <= 1'b0;
    else if (strb.setFlag) flagQ <= 1'b1;
    else if (strb.clrFlag) flagQ <= 1'b0;
  end

  assign irqFlag = flagQ;
  assign irqReq  = flagQ && strb.reqOk;
  assign wakeUp  = irqReq && strb.sleeping;

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setFlag |=> flagQ);
  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !strb.clrFlag) |=> flagQ);
  // R4
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrFlag && !strb.setFlag) |=> !flagQ);
  // R3
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ) |-> $past(strb.setFlag));
endmodule

// File: rtl/minTickIrq.sv
module minTickIrq
  import minTickPkg::*;
#(
  parameter int SEC_PER_MIN   = 60,
  parameter bit USE_PRESCALER = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickIn,
  input  logic srcEnable,
  input  logic globalEnable,
  input  logic emergencyMode,
  input  logic cpuPowerDown,
  input  logic cpuIdle,
  input  logic flagClr,
  output logic irqFlag,
  output logic irqReq,
  output logic wakeUp
);
  flagStrb_t strb;

  minTickCtrl #(
    .SEC_PER_MIN  (SEC_PER_MIN),
    .USE_PRESCALER(USE_PRESCALER)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .tickIn       (tickIn),
    .srcEnable    (srcEnable),
    .globalEnable (globalEnable),
    .emergencyMode(emergencyMode),
    .cpuPowerDown (cpuPowerDown),
    .cpuIdle      (cpuIdle),
    .flagClr      (flagClr),
    .strb         (strb)
  );

  minTickData u_data (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .irqFlag(irqFlag),
    .irqReq (irqReq),
    .wakeUp (wakeUp)
  );

  // R7
  emergency_mute_chk: assert property (@(posedge clk) disable iff (!rstN)
    emergencyMode |-> (!irqReq && !wakeUp));
  // R8
  wake_needs_sleep_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeUp |-> (irqReq && (cpuPowerDown || cpuIdle)));
  // R6
  req_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (irqFlag && srcEnable && globalEnable));
endmodule

// File: tb/minTickIrq_bench.sv
module minTickIrq_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickIn = 1'b0, srcEnable = 1'b0, globalEnable = 1'b0;
  logic emergencyMode = 1'b0, cpuPowerDown = 1'b0, cpuIdle = 1'b0, flagClr = 1'b0;
  logic irqFlag, irqReq, wakeUp;

  int compared = 0;
  int mismatched = 0;
  int refSec = 0;
  bit refFlag = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  minTickIrq u_minTickIrq (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .srcEnable(srcEnable),
    .globalEnable(globalEnable), .emergencyMode(emergencyMode),
    .cpuPowerDown(cpuPowerDown), .cpuIdle(cpuIdle), .flagClr(flagClr),
    .irqFlag(irqFlag), .irqReq(irqReq), .wakeUp(wakeUp)
  );

  task automatic check(string tag, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  function automatic bit refReq();
    return refFlag && srcEnable && globalEnable && !emergencyMode;
  endfunction

  // One clock: model the rising edge with the held inputs, compare at falling edge
  task automatic step();
    @(negedge clk);
    if (rstN) begin
      bit tick;
      tick = tickIn && (refSec == 59);
      if (tickIn) refSec = (refSec == 59) ? 0 : refSec + 1;
      if (tick) refFlag = 1'b1;
      else if (flagClr) refFlag = 1'b0;
    end else begin
      refSec = 0;
      refFlag = 1'b0;
    end
    check("R4 flag", irqFlag, refFlag);
    check("R6 request", irqReq, refReq());
    check("R8 wake", wakeUp, refReq() && (cpuPowerDown || cpuIdle));
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      tickIn = 1'b1;
      step();
    end
    tickIn = 1'b0;
  endtask

  task automatic clearFlag();
    flagClr = 1'b1;
    step();
    flagClr = 1'b0;
  endtask

  initial begin
    step(); step();
    // R1 reset state
    check("R1 flag", irqFlag, 1'b0);
    check("R1 request", irqReq, 1'b0);
    check("R1 wake", wakeUp, 1'b0);
    rstN = 1'b1;
    step();
    check("R1 flag after release", irqFlag, 1'b0);

    srcEnable = 1'b1; globalEnable = 1'b1;
    pulses(59);
    check("R2 no tick at 59", irqFlag, 1'b0);
    pulses(1);
    check("R2 tick at 60", irqFlag, 1'b1);
    check("R6 request on", irqReq, 1'b1);
    for (int i = 0; i < 5; i++) step();
    check("R4 sticky", irqFlag, 1'b1);
    clearFlag();
    check("R4 cleared", irqFlag, 1'b0);

    // R3: enables off, flag still set
    srcEnable = 1'b0;
    pulses(60);
    check("R3 flag local off", irqFlag, 1'b1);
    check("R6 request local off", irqReq, 1'b0);
    srcEnable = 1'b1;
    step();
    check("R6 request follows enable", irqReq, 1'b1);
    clearFlag();
    globalEnable = 1'b0; emergencyMode = 1'b1;
    pulses(60);
    check("R3 flag global off", irqFlag, 1'b1);
    globalEnable = 1'b1; cpuPowerDown = 1'b1;
    step();
    // R7 emergency mutes request and wake
    check("R7 request", irqReq, 1'b0);
    check("R7 wake", wakeUp, 1'b0);
    emergencyMode = 1'b0;
    step();
    check("R8 wake power-down", wakeUp, 1'b1);
    cpuPowerDown = 1'b0; cpuIdle = 1'b1;
    step();
    check("R8 wake idle", wakeUp, 1'b1);
    cpuIdle = 1'b0;
    step();
    check("R8 no wake awake", wakeUp, 1'b0);

    // R5 same-cycle set and clear
    clearFlag();
    pulses(59);
    tickIn = 1'b1; flagClr = 1'b1;
    step();
    tickIn = 1'b0; flagClr = 1'b0;
    check("R5 set wins", irqFlag, 1'b1);
    clearFlag();

    // R9 irregular spacing counts only high cycles
    for (int i = 0; i < 59; i++) begin
      tickIn = 1'b1; step();
      tickIn = 1'b0;
      for (int j = 0; j < (i % 3); j++) step();
    end
    check("R9 no tick after 59 spaced", irqFlag, 1'b0);
    pulses(1);
    check("R9 tick after 60 spaced", irqFlag, 1'b1);
    for (int i = 0; i < 4; i++) step();

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule